// File: doc/BRIEF.md
# Receive Character Queue with Error Tracking

This block sits between a serial receiver and a host register interface. Each character the receiver delivers is stored in a 64-entry first-in first-out queue, together with three per-character condition flags: line break, bad stop bit (framing) and parity mismatch. The host sees two views. The status view is an eight-bit word that is always driven. It reports whether data is waiting, whether a character was lost, the three flags of the oldest stored character, and a summary bit. The summary bit stays high while any stored character still carries a flag. The data view always shows the oldest stored character.

The receiver side is a valid/ready stream, but the receiver cannot be stalled. `in_ready` is low exactly when the queue is full. A beat offered with `in_valid` high while `in_ready` is low is not stored: it is an overrun, and the character is dropped. The host side uses plain strobes. A one-cycle `rd_status` acknowledges the status view and clears the overrun indication. A one-cycle `rd_data` consumes the oldest character. All state changes take effect at the rising clock edge, and both views reflect the new state directly after that edge.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `status_o` is 0x00, `data_o` is 0 and `in_ready` is 1.
- R2: A beat with `in_valid` and `in_ready` both high stores `in_char` with its flags. Characters leave in arrival order, and `data_o` shows the oldest stored character.
- R3: `status_o[4]` is the break flag, `status_o[3]` the framing flag and `status_o[2]` the parity flag of the oldest stored character. With the queue empty, these three bits and `data_o` read 0.
- R4: A `rd_status` strobe without `rd_data` leaves the stored contents, `data_o` and `status_o[4:2]` unchanged.
- R5: A `rd_data` strobe removes the oldest character. On an empty queue it has no effect.
- R6: `status_o[0]` is 1 whenever at least one character is stored.
- R7: `status_o[7]` is 1 while at least one stored character has any flag set. It returns to 0 only once all such characters have been removed.
- R8: The queue holds 64 characters. `in_ready` is 0 exactly while 64 characters are stored.
- R9: A beat offered while full sets `status_o[1]` (overrun) from the next cycle on, drops that character and keeps every stored one. A `rd_status` strobe clears `status_o[1]`. If an overrun and a `rd_status` fall in the same cycle, the flag stays set.
- R10: `status_o[6:5]` always read 0.
- R11: An accepted push and a `rd_data` pop in the same cycle both take effect. Fullness is judged at the start of the cycle, so a push while full is an overrun even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receiver offers a character |
| in_ready | output | 1 | Queue not full |
| in_char | input | 8 | Received character |
| in_brk | input | 1 | Break condition flag for the character |
| in_frm | input | 1 | Framing error flag for the character |
| in_par | input | 1 | Parity error flag for the character |
| rd_status | input | 1 | Host acknowledges the status view |
| rd_data | input | 1 | Host consumes the oldest character |
| status_o | output | 8 | Status view |
| data_o | output | 8 | Oldest stored character |

## Verification
Two collisions matter here. The first is an overrun that coincides with a status acknowledge: the bench fills the queue, then offers a beat in the same cycle as `rd_status`, and expects bit 1 to stay set. The second is a push and a pop in the same cycle, which the bench provokes on an empty queue, on a partly filled queue and on a full one. A reference queue in the bench decides which side takes effect, and the full status word and head character are compared after every such cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  localparam int unsigned RXQ_FLAG_W = 3;

  function automatic logic rxq_flagged(input rxq_flags_t f);
    return f.brk | f.frm | f.par;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [CHAR_W-1:0] push_ch,
  input  rxq_flags_t        push_fl,
  input  logic              pop_req,
  output logic              full,
  output logic              empty,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [CHAR_W-1:0] head_ch,
  output rxq_flags_t        head_fl
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CHAR_W-1:0] mem_ch [DEPTH];
  rxq_flags_t        mem_fl [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign head_ch = mem_ch[rd_ptr];
  assign head_fl = mem_fl[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_ch[wr_ptr] <= push_ch;
      mem_fl[wr_ptr] <= push_fl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int unsigned DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic any_err
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] bad_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   bad_cnt <= bad_cnt + 1'b1;
        2'b01:   bad_cnt <= bad_cnt - 1'b1;
        default: bad_cnt <= bad_cnt;
      endcase
    end
  end

  assign any_err = (bad_cnt != '0);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lost,
  input  logic       ack,
  input  logic       empty,
  input  logic       any_err,
  input  rxq_flags_t head_fl,
  output logic [7:0] status
);
  logic ovr_q;
  rxq_flags_t shown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovr_q <= 1'b0;
    else if (lost) ovr_q <= 1'b1;
    else if (ack)  ovr_q <= 1'b0;
  end

  assign shown  = empty ? '0 : head_fl;
  assign status = {any_err, 2'b00, shown.brk, shown.frm, shown.par, ovr_q, !empty};
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_brk,
  input  logic              in_frm,
  input  logic              in_par,
  input  logic              rd_status,
  input  logic              rd_data,
  output logic [7:0]        status_o,
  output logic [CHAR_W-1:0] data_o
);
  rxq_flags_t        in_fl, head_fl;
  logic [CHAR_W-1:0] head_ch;
  logic              full, empty, push_ok, pop_ok, any_err;

  assign in_fl = '{brk: in_brk, frm: in_frm, par: in_par};

  rxq_store #(.DEPTH(DEPTH), .CHAR_W(CHAR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(in_valid), .push_ch(in_char), .push_fl(in_fl),
    .pop_req(rd_data),
    .full(full), .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok),
    .head_ch(head_ch), .head_fl(head_fl)
  );

  rxq_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n),
    .inc(push_ok && rxq_flagged(in_fl)),
    .dec(pop_ok && rxq_flagged(head_fl)),
    .any_err(any_err)
  );

  rxq_status u_status (
    .clk(clk), .rst_n(rst_n),
    .lost(in_valid && full), .ack(rd_status),
    .empty(empty), .any_err(any_err), .head_fl(head_fl),
    .status(status_o)
  );

  assign in_ready = !full;
  assign data_o   = empty ? '0 : head_ch;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rd_status,
  input logic              rd_data,
  input logic [7:0]        status_o,
  input logic [CHAR_W-1:0] data_o
);
  AST_EMPTY_HEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> (status_o[4:2] == 3'b000 && data_o == '0)); // R3
  AST_STATUS_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !rd_data && !(in_valid && in_ready) && status_o[0])
      |=> ($stable(data_o) && $stable(status_o[4:2]))); // R4
  AST_EMPTY_NO_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> !status_o[7]); // R7
  AST_HEAD_FLAG_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4:2] != 3'b000) |-> status_o[7]); // R7
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> status_o[0]); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> status_o[1]); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00); // R10
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rd_status(rd_status), .rd_data(rd_data), .status_o(status_o), .data_o(data_o)
);

// File: tb/rx_err_fifo_test.sv
`timescale 1ns/1ps
module rx_err_fifo_test;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_brk = 1'b0, in_frm = 1'b0, in_par = 1'b0;
  logic       rd_status = 1'b0, rd_data = 1'b0;
  logic [7:0] in_char = '0;
  logic       in_ready;
  logic [7:0] status_o, data_o;

  int checks = 0;
  int errors = 0;
  logic [10:0] q[$];
  logic ovr = 1'b0;

  always #2.5 clk = ~clk;

  rx_err_fifo uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .in_brk(in_brk), .in_frm(in_frm), .in_par(in_par),
    .rd_status(rd_status), .rd_data(rd_data), .status_o(status_o), .data_o(data_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic bad = 1'b0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) bad = 1'b1;
    return {bad, 2'b00, (q.size() != 0) ? q[0][10:8] : 3'b000, ovr, q.size() != 0};
  endfunction

  // Monitor side of the scoreboard: compare both views against the queue.
  task automatic compare(input string tag);
    logic [7:0] es, ed;
    @(negedge clk);
    es = exp_status();
    ed = (q.size() != 0) ? q[0][7:0] : 8'h00;
    chk(status_o == es, {tag, " status"}, {8'h0, status_o}, {8'h0, es});
    chk(data_o == ed, {tag, " data"}, {8'h0, data_o}, {8'h0, ed});
    chk(in_ready == (q.size() != DEPTH), {tag, " in_ready"}, {15'h0, in_ready},
        {15'h0, q.size() != DEPTH});
  endtask

  // Driver side: one cycle of stimulus, model updated at the edge.
  task automatic step(input logic v, input logic [7:0] ch, input logic [2:0] fl,
                      input logic rs, input logic rd);
    logic was_full, was_empty;
    @(negedge clk);
    in_valid = v; in_char = ch; {in_brk, in_frm, in_par} = fl;
    rd_status = rs; rd_data = rd;
    was_full = (q.size() == DEPTH);
    was_empty = (q.size() == 0);
    @(posedge clk);
    if (rd && !was_empty) void'(q.pop_front());
    if (v && !was_full) q.push_back({fl, ch});
    if (v && was_full) ovr = 1'b1;
    else if (rs) ovr = 1'b0;
    #1;
    in_valid = 1'b0; rd_status = 1'b0; rd_data = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare("R1 R10 reset");

    step(1, 8'h41, 3'b000, 0, 0); compare("R2 R6 first push");
    step(1, 8'h42, 3'b001, 0, 0); compare("R7 summary with clean head");
    step(1, 8'h43, 3'b100, 0, 0); compare("R2 third push");
    step(0, 8'h00, 3'b000, 1, 0); compare("R4 status read no pop");
    step(0, 8'h00, 3'b000, 0, 1); compare("R3 R5 parity head");
    step(0, 8'h00, 3'b000, 0, 1); compare("R3 break head");
    step(0, 8'h00, 3'b000, 0, 1); compare("R7 cleared when drained");
    step(0, 8'h00, 3'b000, 0, 1); compare("R5 pop on empty");
    step(1, 8'h55, 3'b010, 0, 1); compare("R11 push with pop on empty");
    step(1, 8'h66, 3'b000, 0, 1); compare("R11 push with pop");
    step(0, 8'h00, 3'b000, 0, 1); compare("R5 pop last");

    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i + 8'h80), (i == 10) ? 3'b010 : 3'b000, 0, 0);
    compare("R8 full");
    step(1, 8'hEE, 3'b111, 0, 0); compare("R9 overrun set");
    step(0, 8'h00, 3'b000, 1, 0); compare("R9 overrun cleared");
    step(1, 8'hEF, 3'b000, 1, 0); compare("R9 overrun wins over clear");
    step(0, 8'h00, 3'b000, 1, 0); compare("R9 cleared again");
    step(1, 8'hF0, 3'b000, 0, 1); compare("R11 push while full with pop");
    while (q.size() != 0) begin
      step(0, 8'h00, 3'b000, 0, 1); compare("R2 R7 drain order");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule